// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block turns two fault sources into one processor reset. The first source is a digital power-good flag, which comes from an external threshold comparator. The second is a software watchdog. Firmware keeps the watchdog quiet by making transitions on a service input. The reset hold time and the basic watchdog period are parameters counted in clock cycles. A parameter sets the polarity of the reset output.

The watchdog has two periods, chosen by a mode input. In normal mode it expires after the basic period. In extended mode it expires after the basic period times a multiplier, which defaults to 500. The counter restarts when the service input changes level in either direction, or when the mode input changes. A separate flag tells the block whether anything is actually driving the service input. In extended mode, an undriven service input is serviced from inside the block, so the watchdog never fires. In normal mode, an undriven service input does not protect the system. The watchdog can also be switched off with an enable input. The service and mode inputs pass through a two-stage synchronizer before their edges are detected.

Top module: `rstwd_supervisor`

## Requirements
- R1: From the assertion of `rst_n`, and for as long as `pwr_good` stays low afterwards, the reset output is asserted.
- R2: On the first clock edge that samples `pwr_good` low, the reset asserts. It stays asserted on every cycle in which `pwr_good` remains low, whatever the watchdog inputs do.
- R3: Take the first clock edge that samples `pwr_good` high after it was low. Starting with the cycle after that edge, the reset stays asserted for exactly `RST_TICKS` cycles, and then it releases.
- R4: The watchdog counter is zero on every cycle in which reset is asserted. It starts from zero in the first released cycle. If nothing services the watchdog in normal mode, reset stays released for exactly `WD_TICKS` cycles. It then asserts for exactly `RST_TICKS` cycles, and this cycle repeats.
- R5: With `wd_mode_ext` = 1 and no servicing, the released interval lasts exactly `WD_TICKS*EXT_MULT` cycles.
- R6: While `wd_kick_driven` = 1, a change of `wd_kick` in either direction restarts the count. The change must last at least two cycles. The count restarts on the third clock edge after the change, so an expiry follows `WD_TICKS+3` cycles after the change. Any service interval of up to `WD_TICKS-4` cycles keeps reset released indefinitely.
- R7: A change of `wd_mode_ext` restarts the count on the third clock edge after the change. The new mode's period applies from then on.
- R8: With `wd_mode_ext` = 1 and `wd_kick_driven` = 0, the block services itself once the count reaches floor(`WD_TICKS*SELF_PCT/100`) − 1. The watchdog therefore never expires.
- R9: With `wd_mode_ext` = 0 and `wd_kick_driven` = 0, changes on `wd_kick` are ignored, and the watchdog expires after `WD_TICKS` cycles.
- R10: While `wd_enable` = 0, the watchdog never causes a reset. After `wd_enable` rises, expiry comes `WD_TICKS` cycles later.
- R11: With `ACTIVE_HIGH` = 1, `sys_rst` is 1 while reset is asserted. With `ACTIVE_HIGH` = 0, it is the inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pwr_good | input | 1 | Supply-valid flag from the external comparator, already synchronous |
| wd_kick | input | 1 | Watchdog service input; any level change restarts the count |
| wd_mode_ext | input | 1 | 1 selects the extended watchdog period, 0 the basic period |
| wd_kick_driven | input | 1 | 1 when something actively drives `wd_kick` |
| wd_enable | input | 1 | 0 prevents any watchdog expiry |
| sys_rst | output | 1 | Processor reset; polarity set by `ACTIVE_HIGH` |

## Verification
The hardest cases to reach are the exact restart points inside a running period. The count restarts three edges after a service or mode change, and that delay is visible only as a shifted expiry. The bench therefore lines up each stimulus with the first released cycle. It then requires the next reset to appear on one exact cycle, which is `WD_TICKS+3` for a single service edge and a computed index after two mode changes. The self-service case needs more than one full extended period with no reset. The bench runs it that long, so a missed internal service would surface as an expiry.

// File: rtl/rstwd_pkg.sv
package rstwd_pkg;

   typedef enum logic [1:0] {
      ST_PWR_LOW = 2'd0,
      ST_HOLD    = 2'd1,
      ST_RUN     = 2'd2
   } seq_state_t;

   localparam int SIG_KICK = 0;
   localparam int SIG_MODE = 1;
   localparam int SYNC_W   = 2;

   // smallest width that holds values 0..maxv
   function automatic int bits_for(input int maxv);
      int b;
      b = 1;
      while ((64'd1 << b) <= 64'(maxv)) b++;
      return b;
   endfunction

   // count at which the internal service source acts
   function automatic int self_point(input int basic, input int pct);
      int p;
      p = (basic * pct) / 100;
      return (p < 1) ? 1 : p;
   endfunction

endpackage

// File: rtl/rstwd_sync.sv
module rstwd_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstwd_wd_counter.sv
module rstwd_wd_counter
   import rstwd_pkg::*;
#(
   parameter int WD_TICKS = 1000,
   parameter int EXT_MULT = 500,
   parameter int SELF_PCT = 94,
   parameter int CNT_W    = bits_for(WD_TICKS * EXT_MULT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_clr,
   input  logic [SYNC_W-1:0] sync_lvl,
   input  logic              kick_driven,
   input  logic              enable,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              expire_o
);

   localparam int EXT_P   = WD_TICKS * EXT_MULT;
   localparam int SELF_AT = self_point(WD_TICKS, SELF_PCT);
   localparam logic [CNT_W-1:0] BASE_LAST = CNT_W'(WD_TICKS - 1);
   localparam logic [CNT_W-1:0] EXT_LAST  = CNT_W'(EXT_P - 1);
   localparam logic [CNT_W-1:0] SELF_LAST = CNT_W'(SELF_AT - 1);

   logic [SYNC_W-1:0] lvl_prev_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  last_cnt;
   logic              kick_edge, mode_edge, mode_ext;
   logic              self_kick, clr, expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev_q <= '0;
      else        lvl_prev_q <= sync_lvl;
   end

   assign kick_edge = sync_lvl[SIG_KICK] ^ lvl_prev_q[SIG_KICK];
   assign mode_edge = sync_lvl[SIG_MODE] ^ lvl_prev_q[SIG_MODE];
   assign mode_ext  = sync_lvl[SIG_MODE];

   generate
      if (EXT_MULT == 1) begin : g_single_period
         assign last_cnt = BASE_LAST;
      end else begin : g_dual_period
         assign last_cnt = mode_ext ? EXT_LAST : BASE_LAST;
      end
   endgenerate

   // undriven service input in long mode: internal source restarts the count
   assign self_kick = mode_ext & ~kick_driven & (cnt_q >= SELF_LAST);

   assign clr = hold_clr | ~enable | mode_edge | self_kick |
                (kick_edge & kick_driven);

   assign expire = ~clr & (cnt_q == last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr || expire)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o    = cnt_q;
   assign expire_o = expire;

endmodule

// File: rtl/rstwd_rst_seq.sv
module rstwd_rst_seq
   import rstwd_pkg::*;
#(
   parameter int RST_TICKS = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic wd_expire,
   output logic rst_act_o
);

   localparam int TW = bits_for(RST_TICKS);
   localparam logic [TW-1:0] T_LAST = TW'(RST_TICKS - 1);

   seq_state_t     st_q, st_d;
   logic [TW-1:0]  t_q, t_d;

   always_comb begin
      st_d = st_q;
      t_d  = t_q;
      case (st_q)
         ST_PWR_LOW: begin
            t_d = '0;
            if (pwr_good) st_d = ST_HOLD;
         end
         ST_HOLD: begin
            if (!pwr_good) begin
               st_d = ST_PWR_LOW;
               t_d  = '0;
            end else if (t_q == T_LAST) begin
               st_d = ST_RUN;
               t_d  = '0;
            end else begin
               t_d  = t_q + 1'b1;
            end
         end
         ST_RUN: begin
            t_d = '0;
            if (!pwr_good)      st_d = ST_PWR_LOW;
            else if (wd_expire) st_d = ST_HOLD;
         end
         default: begin
            st_d = ST_PWR_LOW;
            t_d  = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_PWR_LOW;
         t_q  <= '0;
      end else begin
         st_q <= st_d;
         t_q  <= t_d;
      end
   end

   assign rst_act_o = (st_q != ST_RUN);

endmodule

// File: rtl/rstwd_supervisor.sv
module rstwd_supervisor
   import rstwd_pkg::*;
#(
   parameter int RST_TICKS   = 200,
   parameter int WD_TICKS    = 1000,
   parameter int EXT_MULT    = 500,
   parameter int SELF_PCT    = 94,
   parameter int SYNC_STAGES = 2,
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic wd_kick,
   input  logic wd_mode_ext,
   input  logic wd_kick_driven,
   input  logic wd_enable,
   output logic sys_rst
);

   localparam int CNT_W = bits_for(WD_TICKS * EXT_MULT);

   generate
      if (RST_TICKS < 1) begin : g_bad_rst
         $error("RST_TICKS must be at least 1");
      end
      if (WD_TICKS < 4) begin : g_bad_wd
         $error("WD_TICKS must be at least 4");
      end
      if (EXT_MULT < 1) begin : g_bad_mult
         $error("EXT_MULT must be at least 1");
      end
      if (SELF_PCT < 1 || SELF_PCT > 99) begin : g_bad_pct
         $error("SELF_PCT must lie in 1..99");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_W-1:0] raw_in, sync_q;
   logic              rst_act;
   logic              wd_expire;
   logic [CNT_W-1:0]  wd_cnt;

   assign raw_in[SIG_KICK] = wd_kick;
   assign raw_in[SIG_MODE] = wd_mode_ext;

   rstwd_sync #(
      .W      (SYNC_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (sync_q)
   );

   rstwd_wd_counter #(
      .WD_TICKS (WD_TICKS),
      .EXT_MULT (EXT_MULT),
      .SELF_PCT (SELF_PCT),
      .CNT_W    (CNT_W)
   ) u_wd (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold_clr    (rst_act | ~pwr_good),
      .sync_lvl    (sync_q),
      .kick_driven (wd_kick_driven),
      .enable      (wd_enable),
      .cnt_o       (wd_cnt),
      .expire_o    (wd_expire)
   );

   rstwd_rst_seq #(
      .RST_TICKS (RST_TICKS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_good  (pwr_good),
      .wd_expire (wd_expire),
      .rst_act_o (rst_act)
   );

   generate
      if (ACTIVE_HIGH) begin : g_out_high
         assign sys_rst = rst_act;
      end else begin : g_out_low
         assign sys_rst = ~rst_act;
      end
   endgenerate

endmodule

// File: rtl/rstwd_checker.sv
module rstwd_checker #(
   parameter int RST_TICKS = 200,
   parameter int CNT_W     = 19
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_good,
   input logic             wd_kick_driven,
   input logic             wd_enable,
   input logic             rst_act,
   input logic             mode_lvl,
   input logic [CNT_W-1:0] wd_cnt
);

   localparam int HW = $clog2(RST_TICKS + 2) + 1;

   logic          pg_q;
   logic [HW-1:0] hold_len;

   // consecutive reset cycles with power good held since the previous cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_q     <= 1'b0;
         hold_len <= '0;
      end else begin
         pg_q <= pwr_good;
         if (rst_act && pwr_good && pg_q) begin
            if (hold_len != '1) hold_len <= hold_len + 1'b1;
         end else begin
            hold_len <= '0;
         end
      end
   end

   assert_pg_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> rst_act);

   assert_hold_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_act) |-> (hold_len == HW'(RST_TICKS)));

   assert_release_needs_pg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_act) |-> $past(pwr_good));

   assert_count_zero_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_act |-> (wd_cnt == '0));

   assert_self_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_lvl && !wd_kick_driven && pwr_good && !rst_act) |=> !rst_act);

   assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wd_enable && pwr_good && !rst_act) |=> !rst_act);

endmodule

bind rstwd_supervisor rstwd_checker #(
   .RST_TICKS (RST_TICKS),
   .CNT_W     (CNT_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .pwr_good       (pwr_good),
   .wd_kick_driven (wd_kick_driven),
   .wd_enable      (wd_enable),
   .rst_act        (rst_act),
   .mode_lvl       (sync_q[rstwd_pkg::SIG_MODE]),
   .wd_cnt         (wd_cnt)
);

// File: tb/rstwd_supervisor_tb.sv
`timescale 1ns/1ps
module rstwd_supervisor_tb;

   localparam int RT = 12;
   localparam int WT = 20;
   localparam int EM = 500;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pg = 1'b0;
   logic kick_man = 1'b0;
   logic kick_auto = 1'b0;
   logic auto_en = 1'b0;
   logic mode = 1'b0;
   logic drv = 1'b1;
   logic en = 1'b1;
   logic kick;
   logic sys_rst, sys_rst_lo;

   int checks = 0;
   int fails = 0;
   int pol_err = 0;
   int auto_cnt = 0;

   assign kick = kick_man ^ kick_auto;

   always #2.5 clk = ~clk;

   rstwd_supervisor #(
      .RST_TICKS(RT), .WD_TICKS(WT), .EXT_MULT(EM), .SELF_PCT(94),
      .SYNC_STAGES(2), .ACTIVE_HIGH(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_good(pg), .wd_kick(kick),
      .wd_mode_ext(mode), .wd_kick_driven(drv), .wd_enable(en),
      .sys_rst(sys_rst)
   );

   rstwd_supervisor #(
      .RST_TICKS(RT), .WD_TICKS(WT), .EXT_MULT(EM), .SELF_PCT(94),
      .SYNC_STAGES(2), .ACTIVE_HIGH(1'b0)
   ) u_dut_lo (
      .clk(clk), .rst_n(rst_n), .pwr_good(pg), .wd_kick(kick),
      .wd_mode_ext(mode), .wd_kick_driven(drv), .wd_enable(en),
      .sys_rst(sys_rst_lo)
   );

   // background service toggling every five cycles
   always @(negedge clk) begin
      if (auto_en) begin
         if (auto_cnt == 4) begin
            auto_cnt  <= 0;
            kick_auto <= ~kick_auto;
         end else begin
            auto_cnt <= auto_cnt + 1;
         end
      end
   end

   // R11: the inverted-polarity copy must mirror the main output
   always @(negedge clk) begin
      if (rst_n && (sys_rst_lo !== ~sys_rst)) pol_err++;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic measure(input logic lvl, output int n);
      n = 0;
      while (sys_rst === lvl && n < 20000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic first_rst(input int limit, output int idx);
      idx = -1;
      for (int k = 1; k <= limit; k++) begin
         @(negedge clk);
         if (sys_rst === 1'b1) begin
            idx = k;
            break;
         end
      end
   endtask

   task automatic quiet(input int len, output int hits);
      hits = 0;
      repeat (len) begin
         @(negedge clk);
         if (sys_rst !== 1'b0) hits++;
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      finish_run();
   end

   initial begin
      int n, idx, hits, since;

      repeat (3) @(negedge clk);
      chk(sys_rst === 1'b1, "R1 reset during power-on", sys_rst, 1);
      chk(sys_rst_lo === 1'b0, "R11 active-low copy during power-on", sys_rst_lo, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(sys_rst === 1'b1, "R1 held while power-good low", sys_rst, 1);

      // R3: release after RT cycles
      pg = 1'b1;
      @(negedge clk);
      measure(1'b1, n);
      chk(n == RT, "R3 first release hold", n, RT);

      // R4: unserviced cycling
      measure(1'b0, n);
      chk(n == WT, "R4 first run length", n, WT);
      measure(1'b1, n);
      chk(n == RT, "R4 expiry pulse width", n, RT);
      measure(1'b0, n);
      chk(n == WT, "R4 run restarts from zero", n, WT);
      measure(1'b1, n);
      chk(n == RT, "R4 second pulse width", n, RT);

      // R2: power-good drop, kicks ignored while low
      repeat (5) @(negedge clk);
      pg = 1'b0;
      first_rst(3, idx);
      chk(idx == 1, "R2 assert on next edge", idx, 1);
      hits = 0;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (sys_rst !== 1'b1) hits++;
         if (k % 3 == 0) kick_man = ~kick_man;
      end
      chk(hits == 0, "R2 held while power-good low", hits, 0);
      pg = 1'b1;
      @(negedge clk);
      measure(1'b1, n);
      chk(n == RT, "R3 release after power-good return", n, RT);

      // R6: sweep of service intervals short enough to keep reset off
      since = 0;
      for (int iv = 2; iv <= WT - 4; iv++) begin
         hits = 0;
         for (int k = 0; k < 120; k++) begin
            @(negedge clk);
            if (sys_rst !== 1'b0) hits++;
            since++;
            if (since >= iv) begin
               kick_man = ~kick_man;
               since = 0;
            end
         end
         chk(hits == 0, $sformatf("R6 service interval %0d", iv), hits, 0);
      end
      first_rst(40, idx);
      chk(idx > 0, "R6 expiry once service stops", idx, 1);
      measure(1'b1, n);

      // R6: single edges at the first released cycle, both directions
      kick_man = ~kick_man;
      first_rst(40, idx);
      chk(idx == WT + 3, "R6 restart by one service edge (a)", idx, WT + 3);
      measure(1'b1, n);
      kick_man = ~kick_man;
      first_rst(40, idx);
      chk(idx == WT + 3, "R6 restart by one service edge (b)", idx, WT + 3);
      measure(1'b1, n);

      // R7: two mode changes restart the count
      idx = -1;
      for (int k = 1; k <= 80; k++) begin
         @(negedge clk);
         if (sys_rst === 1'b1) begin
            idx = k;
            break;
         end
         if (k == 15 || k == 25) mode = ~mode;
      end
      chk(idx == 48, "R7 mode changes restart count", idx, 48);

      // R5: extended period
      mode = 1'b1;
      measure(1'b1, n);
      chk(n == RT, "R4 pulse width before extended run", n, RT);
      measure(1'b0, n);
      chk(n == WT * EM, "R5 extended run length", n, WT * EM);

      // R8: undriven service input in extended mode never expires
      drv = 1'b0;
      measure(1'b1, n);
      chk(n == RT, "R4 pulse width before self-service", n, RT);
      quiet(WT * EM + 500, hits);
      chk(hits == 0, "R8 self-service prevents expiry", hits, 0);

      // R9: undriven service input in normal mode, kicks ignored
      mode = 1'b0;
      auto_en = 1'b1;
      first_rst(60, idx);
      chk(idx == WT + 3, "R9 expiry despite undriven kicks", idx, WT + 3);
      measure(1'b1, n);
      measure(1'b0, n);
      chk(n == WT, "R9 run length with ignored kicks", n, WT);

      // R10: watchdog disabled
      auto_en = 1'b0;
      drv = 1'b1;
      en = 1'b0;
      measure(1'b1, n);
      chk(n == RT, "R4 pulse width before disable", n, RT);
      quiet(100, hits);
      chk(hits == 0, "R10 no expiry while disabled", hits, 0);
      en = 1'b1;
      first_rst(40, idx);
      chk(idx == WT, "R10 expiry after enable", idx, WT);

      chk(pol_err == 0, "R11 polarity mirror mismatches", pol_err, 0);
      chk(sys_rst_lo === ~sys_rst, "R11 polarity at end", sys_rst_lo, ~sys_rst);

      finish_run();
   end

endmodule